// File: doc/BRIEF.md
# Distributed-Arithmetic Four-Tap Inner-Product Engine

This block forms the dot product of four signed coefficients with a sliding window of the four most recent signed input samples, and it uses no multiplier. A register table holds the sum of every non-empty subset of the window. Each new sample rebuilds the table in one clock with seven parallel adders. The adders reuse the previous table, because entries that exclude the newest sample are the old entries with the index shifted up by one position.

A start pulse latches the coefficients and a desired sample. On each of the next L clocks, one bit position taken across all four coefficients is used as a 4-bit address. The address is applied least significant first, and it selects a table entry through a 16-to-1 multiplexer. A carry-save accumulator adds the selected entry to its own contents shifted right by one bit, and it keeps the bits that fall out of the bottom as the low part of the result. On the sign position the entry is inverted. A single final adder then combines the sum and carry words with a forced carry-in of one, which completes the subtraction for the sign position. The engine also reports the error, which is the desired value minus the result.

Top module: `da_inner_engine`

## Requirements
- R1: After reset, `done` and `y_valid` are low, and `y_out` and `err_out` are zero.
- R2: `y_out` equals the sum over k = 0..3 of w_k * x_k. Coefficient w_k is the two's-complement lane `weights[k*WW +: WW]`. Sample x_0 is the newest accepted sample and x_3 is the oldest.
- R3: `err_out` equals `desired` (latched with the accepted start) minus `y_out`, computed with one extra bit so that it cannot overflow.
- R4: `done` is high for exactly one cycle. It rises on the (WW+1)-th rising edge after the edge that accepted `start`. `y_valid` rises with it and stays high until the next accepted start.
- R5: Each cycle with `sample_vld` high shifts `sample_in` into the window as x_0 and discards the old x_3. Samples never go into the window without `sample_vld`.
- R6: A `start` that arrives while `busy` is high is ignored. The running computation finishes with its original coefficients and desired value.
- R7: The sign bit of each coefficient carries negative weight. The most negative coefficients and samples give exact results, for example 4 * (-128) * (-128) = 65536 for 8-bit operands.
- R8: A sample accepted on the same edge as `start` is part of that computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | Shift `sample_in` into the window |
| sample_in | input | DW | New signed sample |
| start | input | 1 | Begin a computation; accepted only when idle |
| weights | input | 4*WW | Four signed coefficients, lane k at bits k*WW +: WW |
| desired | input | YW | Signed desired value, latched with start |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle strobe marking new results |
| y_valid | output | 1 | Result registers hold a finished result |
| y_out | output | YW | Signed inner product |
| err_out | output | YW+1 | Signed desired minus result |

## Verification
The checks assume that no sample arrives while the engine is busy. A sample during accumulation would rewrite the table in the middle of a run, and one assertion flags any such sample. The bench pushes samples only between runs, or on the very edge that accepts start. It may pulse start while the engine is busy, because the engine must ignore that pulse. The checks also assume that the desired value fits in its YW-bit port. The bench keeps its stimulus within that range.

// File: rtl/da_inner_pkg.sv
package da_inner_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} eng_state_t;
endpackage

// File: rtl/da_subset_table.sv
module da_subset_table #(
  parameter int DW = 8,
  parameter int TW = DW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [DW-1:0]     sample_in,
  output logic [16*TW-1:0]  tbl_o
);
  logic [TW-1:0] tbl_q [16];
  logic [TW-1:0] add_w [8];
  logic [TW-1:0] ext_w;

  assign ext_w    = {{(TW-DW){sample_in[DW-1]}}, sample_in};
  assign add_w[0] = ext_w;

  // seven adders: subsets that contain the newest sample
  for (genvar g = 1; g < 8; g++) begin : g_add
    assign add_w[g] = tbl_q[g] + ext_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) tbl_q[i] <= '0;
    end else if (shift_en) begin
      for (int m = 0; m < 8; m++) begin
        tbl_q[2*m]   <= tbl_q[m];
        tbl_q[2*m+1] <= add_w[m];
      end
    end
  end

  for (genvar g = 0; g < 16; g++) begin : g_flat
    assign tbl_o[g*TW +: TW] = tbl_q[g];
  end

  // R5
  newest_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> tbl_q[1] == $past(ext_w));
  // R5
  age_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> tbl_q[2] == $past(tbl_q[1]));
endmodule

// File: rtl/da_slice_mux.sv
module da_slice_mux #(
  parameter int TW = 10
) (
  input  logic [16*TW-1:0] tbl_i,
  input  logic [3:0]       sel,
  output logic [TW-1:0]    entry_o
);
  always_comb entry_o = tbl_i[int'(sel)*TW +: TW];
endmodule

// File: rtl/da_csa_accum.sv
module da_csa_accum #(
  parameter int TW = 10,
  parameter int WW = 8,
  parameter int HW = 11,
  localparam int AW = HW + WW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          msb,
  input  logic [TW-1:0] entry,
  output logic [HW-1:0] sum_o,
  output logic [HW-1:0] carry_o,
  output logic [WW-1:0] low_o
);
  logic [AW-1:0] s_q, c_q, ent_x, sh_s, sh_c, ns, nc;
  logic [WW-1:0] low_q;

  function automatic logic [2*AW-1:0] csa3(logic [AW-1:0] a, logic [AW-1:0] b,
                                           logic [AW-1:0] e);
    logic [AW-1:0] s, c;
    s = a ^ b ^ e;
    c = ((a & b) | (a & e) | (b & e)) << 1;
    return {c, s};
  endfunction

  always_comb begin
    ent_x = {{(AW-TW){entry[TW-1]}}, entry};
    if (msb) ent_x = ~ent_x;
    sh_s = {s_q[AW-1], s_q[AW-1:1]};
    sh_c = {c_q[AW-1], c_q[AW-1:1]};
    {nc, ns} = csa3(sh_s, sh_c, ent_x);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      s_q <= '0; c_q <= '0; low_q <= '0;
    end else if (step) begin
      s_q   <= ns;
      c_q   <= nc;
      low_q <= {s_q[0], low_q[WW-1:1]};
    end
  end

  assign sum_o   = s_q[HW-1:0];
  assign carry_o = c_q[HW-1:0];
  assign low_o   = low_q;

  // R2
  cleared_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (s_q == '0 && c_q == '0 && low_q == '0));
endmodule

// File: rtl/da_inner_engine.sv
module da_inner_engine #(
  parameter int DW = 8,
  parameter int WW = 8,
  localparam int TW = DW + 2,
  localparam int HW = DW + 3,
  localparam int YW = DW + WW + 2,
  localparam int CW = $clog2(WW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_vld,
  input  logic [DW-1:0]   sample_in,
  input  logic            start,
  input  logic [4*WW-1:0] weights,
  input  logic [YW-1:0]   desired,
  output logic            busy,
  output logic            done,
  output logic            y_valid,
  output logic [YW-1:0]   y_out,
  output logic [YW:0]     err_out
);
  import da_inner_pkg::*;

  eng_state_t      state_q;
  logic [CW-1:0]   cnt_q;
  logic [4*WW-1:0] w_q;
  logic [YW-1:0]   d_q;
  logic [16*TW-1:0] tbl_w;
  logic [3:0]      sel_w;
  logic [TW-1:0]   entry_w;
  logic [HW-1:0]   sum_w, carry_w, high_w;
  logic [WW-1:0]   low_w;
  logic [YW-1:0]   y_w;
  logic            accept_w, step_w, msb_w, last_w;

  assign accept_w = (state_q == ST_IDLE) && start;
  assign step_w   = (state_q == ST_RUN);
  assign last_w   = (cnt_q == CW'(WW-1));
  assign msb_w    = last_w;
  assign busy     = (state_q != ST_IDLE);

  for (genvar k = 0; k < 4; k++) begin : g_slice
    assign sel_w[k] = w_q[k*WW + int'(cnt_q)];
  end

  da_subset_table #(.DW(DW), .TW(TW)) u_table (
    .clk(clk), .rst_n(rst_n), .shift_en(sample_vld),
    .sample_in(sample_in), .tbl_o(tbl_w));

  da_slice_mux #(.TW(TW)) u_mux (.tbl_i(tbl_w), .sel(sel_w), .entry_o(entry_w));

  da_csa_accum #(.TW(TW), .WW(WW), .HW(HW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(accept_w), .step(step_w), .msb(msb_w),
    .entry(entry_w), .sum_o(sum_w), .carry_o(carry_w), .low_o(low_w));

  // final add with forced carry-in completes the sign-slice subtraction
  assign high_w = sum_w + carry_w + HW'(1);
  assign y_w    = {high_w, low_w[WW-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q <= '0; w_q <= '0; d_q <= '0;
      done <= 1'b0; y_valid <= 1'b0; y_out <= '0; err_out <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN; cnt_q <= '0; w_q <= weights; d_q <= desired;
          y_valid <= 1'b0;
        end
        ST_RUN: begin
          if (last_w) state_q <= ST_FIN;
          else        cnt_q   <= cnt_q + CW'(1);
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
          y_out   <= y_w;
          err_out <= {d_q[YW-1], d_q} - {y_w[YW-1], y_w};
          done    <= 1'b1;
          y_valid <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  valid_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> y_valid);
  // R4
  fin_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN) |=> done);
  // R6
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(w_q) && $stable(d_q)));
  // R5
  no_sample_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sample_vld);
endmodule

// File: tb/tb_da_inner_engine.sv
module tb_da_inner_engine;
  localparam int DW = 8;
  localparam int WW = 8;
  localparam int YW = DW + WW + 2;
  localparam int NV = 6;

  localparam logic [31:0] VS [NV] = '{32'h01020304, 32'hFF7F8005, 32'h10203040,
                                      32'hF0E0D0C0, 32'h55AA33CC, 32'h807F0001};
  localparam logic [31:0] VW [NV] = '{32'h01010101, 32'h80FF7F02, 32'h00000000,
                                      32'h7F7F7F7F, 32'hC35A0F81, 32'h01800180};
  localparam logic signed [YW-1:0] VD [NV] = '{18'sd10, -18'sd300, 18'sd5,
                                               18'sd0, 18'sd1234, -18'sd77};

  logic clk = 1'b0, rst_n = 1'b0, sample_vld = 1'b0, start = 1'b0;
  logic [DW-1:0] sample_in = '0;
  logic [4*WW-1:0] weights = '0;
  logic [YW-1:0] desired = '0;
  logic busy, done, y_valid;
  logic [YW-1:0] y_out;
  logic [YW:0] err_out;

  int total = 0, bad = 0, cycles = 0;
  logic signed [DW-1:0] win [4];

  always #10 clk = ~clk;

  da_inner_engine #(.DW(DW), .WW(WW)) dut (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .sample_in(sample_in),
    .start(start), .weights(weights), .desired(desired), .busy(busy),
    .done(done), .y_valid(y_valid), .y_out(y_out), .err_out(err_out));

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model(logic [31:0] w);
    longint acc = 0;
    for (int k = 0; k < 4; k++) acc += longint'(win[k]) * longint'($signed(w[k*8 +: 8]));
    return acc;
  endfunction

  task automatic win_push(logic [7:0] s);
    win[3] = win[2]; win[2] = win[1]; win[1] = win[0]; win[0] = s;
  endtask

  task automatic push(logic [7:0] s);
    @(negedge clk); sample_vld = 1'b1; sample_in = s; win_push(s);
    @(negedge clk); sample_vld = 1'b0;
  endtask

  // drive start (optionally with a same-edge sample), check latency and results
  task automatic run(logic [31:0] w, logic signed [YW-1:0] d, string req,
                     bit with_push, logic [7:0] s, bit poke);
    longint ey;
    @(negedge clk);
    start = 1'b1; weights = w; desired = d;
    if (with_push) begin sample_vld = 1'b1; sample_in = s; win_push(s); end
    ey = model(w);
    @(negedge clk);
    start = 1'b0; sample_vld = 1'b0;
    for (int k = 1; k <= WW + 1; k++) begin
      if (poke && k == 3) begin start = 1'b1; weights = ~w; desired = ~d; end
      @(negedge clk);
      start = 1'b0;
      if (k == WW + 1) chk("R4 done at latency", done, 1);
      else if (k == WW) chk("R4 done early", done, 0);
    end
    chk("R4 valid with done", y_valid, 1);
    chk(req, longint'($signed(y_out)), ey);
    chk("R3 error", longint'($signed(err_out)), longint'(d) - ey);
    @(negedge clk);
    chk("R4 done one cycle", done, 0);
    chk("R4 valid holds", y_valid, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) win[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 y_valid", y_valid, 0);
    chk("R1 y_out", y_out, 0);
    chk("R1 err_out", err_out, 0);

    // R2 vector table
    for (int i = 0; i < NV; i++) begin
      for (int b = 3; b >= 0; b--) push(VS[i][b*8 +: 8]);
      run(VW[i], VD[i], "R2 inner product", 1'b0, 8'h00, 1'b0);
    end

    // R7 extremes
    for (int b = 0; b < 4; b++) push(8'h80);
    run(32'h80808080, 18'sd100, "R7 most negative", 1'b0, 8'h00, 1'b0);
    chk("R7 value 65536", longint'($signed(y_out)), 65536);
    run(32'h7F7F7F7F, -18'sd5, "R7 max by min", 1'b0, 8'h00, 1'b0);

    // R5 sliding window: one new sample displaces the oldest
    push(8'h01);
    run(32'h01010101, 18'sd0, "R5 window shift", 1'b0, 8'h00, 1'b0);
    chk("R5 value -383", longint'($signed(y_out)), -383);

    // R8 sample on the same edge as start is used
    run(32'h00000001, 18'sd9, "R8 same-edge sample", 1'b1, 8'h05, 1'b0);
    chk("R8 value 5", longint'($signed(y_out)), 5);

    // R6 start while busy has no effect on the running result
    run(32'h03FE05FB, -18'sd40, "R6 start ignored", 1'b0, 8'h00, 1'b1);
    @(negedge clk);
    chk("R6 engine idle after ignored start", busy, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule